// File: doc/BRIEF.md
# Master SPI Engine Inside a Serial Port

This block is the transmit and receive datapath of a serial port that runs as a master-only SPI port when its mode field selects that mode. Software reaches it through a small register window. It can set the receiver and transmitter enables, the frame format (mode, bit order, clock phase, clock polarity) and a baud divider. It writes bytes into a one-entry transmit buffer, reads received bytes from a receive buffer, and watches two status flags.

On the serial side the block drives the transfer clock and the transmit line, and it samples the receive line. The clock exists only while the transmitter is shifting a byte. A byte waiting in the buffer follows the current one without an idle gap. Turning the transmitter off takes effect only after everything queued has left the shift register. Turning the receiver off empties the receive buffer at once.

Top module: `uspi_top`

## Requirements
- R1: FORMAT (address 3) holds the mode in bits [1:0], least-significant-first in bit 2, clock phase in bit 3 and clock polarity in bit 4, and one write sets them all. Only mode 2'b11 runs the engine. With modes 00, 01 or 10 a DATA write (address 0) starts nothing, the clock does not toggle and `txd_oe` stays low.
- R2: Reserved bits read as zero. Writing 8'hFF to CTRL (address 2) reads back 8'h03, and writing 8'hFF to FORMAT reads back 8'h1F.
- R3: With bit 2 of FORMAT set, the transmit line carries bit 0 first. With it clear, bit 7 goes first. The receive byte is assembled in the same order.
- R4: With clock phase 0, data is sampled on the leading clock edge of each bit and the transmit line changes on the trailing edge. With phase 1 the line changes on the leading edge and data is sampled on the trailing edge. A byte sent with the receive line looped to the transmit line reads back unchanged.
- R5: Between bytes the transfer clock rests at the clock polarity bit. After reset it rests at 0.
- R6: Each half period of the transfer clock lasts BAUD+1 clock cycles (BAUD at address 4). A byte takes exactly 16 clock edges.
- R7: STATUS (address 1) bit 0 (transmit buffer empty) is 1 after reset. It goes low when a DATA write is accepted and returns to 1 when the buffer moves into the shift register. A DATA write while the buffer is full is ignored.
- R8: STATUS bit 1 (receive complete) is set when the 8th bit has been captured and the byte has been copied to the receive buffer. A read of DATA returns that byte and clears the flag.
- R9: A byte that is already buffered when the current byte ends starts at once. The clock edges of the two bytes are evenly spaced, with no idle gap between them.
- R10: Clearing the transmitter enable (CTRL bit 1) leaves `txd_oe` high until both the shift register and the buffer are empty. After that `txd_oe` goes low.
- R11: Clearing the receiver enable (CTRL bit 0) clears the receive buffer to 8'h00 and clears the receive complete flag at once. While the receiver is disabled, no byte is captured.
- R12: With the transmitter disabled, DATA writes are ignored and no transfer takes place, even when the receiver is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (side effects on DATA) |
| bus_addr | input | 3 | Register address: 0 DATA, 1 STATUS, 2 CTRL, 3 FORMAT, 4 BAUD |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data, combinational from address |
| xclk | output | 1 | Transfer clock |
| txd | output | 1 | Transmit line |
| txd_oe | output | 1 | High while the block drives the transmit line |
| rxd | input | 1 | Receive line |

## Verification
Assertions check four properties on every cycle:
- the clock rests at the polarity level whenever the engine is idle;
- the transmit line never changes right after a sampling edge;
- a transfer runs only while the transmitter is effectively enabled and only in master SPI mode;
- the line is released only after the drain, and a disabled receiver always holds an empty buffer with its flag clear.

Some behaviours need the bench's scenarios instead, because they depend on what the far end of the link sees. These are bit order, edge count and edge spacing across back-to-back bytes, and a byte going out and coming back intact in all eight format combinations. They also cover the flag sequences seen through the register window and the writes that must be ignored.

// File: rtl/uspi_pkg.sv
package uspi_pkg;

    localparam int unsigned REG_W = 8;

    typedef enum logic [2:0] {
        A_DATA = 3'd0,
        A_STAT = 3'd1,
        A_CTRL = 3'd2,
        A_FMT  = 3'd3,
        A_BAUD = 3'd4
    } addr_e;

    typedef enum logic [1:0] {
        M_ASYNC = 2'b00,
        M_SYNC  = 2'b01,
        M_RSVD  = 2'b10,
        M_SPI   = 2'b11
    } mode_e;

    // bit 4 polarity, bit 3 phase, bit 2 lsb first, bits 1:0 mode
    typedef struct packed {
        logic  cpol;
        logic  cpha;
        logic  lsb_first;
        mode_e mode;
    } fmt_t;

endpackage

// File: rtl/uspi_baud.sv
module uspi_baud #(
    parameter int unsigned DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] limit,
    output logic             tick
);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } st_t;

    st_t s_q, s_d;

    always_comb begin
        s_d  = s_q;
        tick = 1'b0;
        if (!run) begin
            s_d.cnt = '0;
        end else if (s_q.cnt >= limit) begin
            tick    = 1'b1;
            s_d.cnt = '0;
        end else begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

endmodule

// File: rtl/uspi_shift.sv
module uspi_shift #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              halt,
    input  logic              start,
    input  logic [DATA_W-1:0] din,
    input  logic              tick,
    input  logic              cpol,
    input  logic              cpha,
    input  logic              lsb_first,
    input  logic              miso,
    output logic              active,
    output logic              last_edge,
    output logic              sck,
    output logic              mosi,
    output logic [DATA_W-1:0] rx_word
);

    localparam int unsigned EDGES = 2 * DATA_W;
    localparam int unsigned HC_W  = $clog2(EDGES);

    typedef struct packed {
        logic              active;
        logic [HC_W-1:0]   hcnt;
        logic              sck;
        logic              mosi;
        logic [DATA_W-1:0] tx_sr;
        logic [DATA_W-1:0] rx_sr;
    } st_t;

    st_t  s_q, s_d;
    logic edge_ev;
    logic lead;
    logic sample_ev;

    function automatic logic head_bit(input logic [DATA_W-1:0] v, input logic lsb);
        return lsb ? v[0] : v[DATA_W-1];
    endfunction

    function automatic logic [DATA_W-1:0] drop_bit(input logic [DATA_W-1:0] v, input logic lsb);
        return lsb ? {1'b0, v[DATA_W-1:1]} : {v[DATA_W-2:0], 1'b0};
    endfunction

    always_comb begin
        s_d       = s_q;
        edge_ev   = s_q.active && tick;
        lead      = ~s_q.hcnt[0];
        sample_ev = edge_ev && (lead ^ cpha);
        last_edge = edge_ev && (s_q.hcnt == HC_W'(EDGES - 1));

        if (edge_ev) begin
            s_d.sck  = ~s_q.sck;
            s_d.hcnt = s_q.hcnt + 1'b1;
            if (lead ^ cpha) begin
                s_d.rx_sr = lsb_first ? {miso, s_q.rx_sr[DATA_W-1:1]}
                                      : {s_q.rx_sr[DATA_W-2:0], miso};
            end else if (cpha || !last_edge) begin
                s_d.mosi  = head_bit(s_q.tx_sr, lsb_first);
                s_d.tx_sr = drop_bit(s_q.tx_sr, lsb_first);
            end
        end

        if (last_edge) begin
            s_d.active = 1'b0;
            s_d.hcnt   = '0;
            s_d.sck    = cpol;
        end

        if (!s_q.active) begin
            s_d.sck = cpol;
        end

        if (start) begin
            s_d.active = 1'b1;
            s_d.hcnt   = '0;
            s_d.sck    = cpol;
            s_d.tx_sr  = din;
            if (!cpha) begin
                s_d.mosi  = head_bit(din, lsb_first);
                s_d.tx_sr = drop_bit(din, lsb_first);
            end
        end

        if (halt) begin
            s_d.active = 1'b0;
            s_d.hcnt   = '0;
            s_d.sck    = cpol;
        end

        rx_word = s_d.rx_sr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.mosi <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign active = s_q.active;
    assign sck    = s_q.sck;
    assign mosi   = s_q.mosi;

    AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        !s_q.active && !$past(s_q.active) && $stable(cpol) |-> s_q.sck == cpol) // R5
        else $error("idle clock level differs from polarity");

    AST_MOSI_HOLD_AT_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
        sample_ev |=> $stable(s_q.mosi)) // R4
        else $error("transmit line moved right after a sampling edge");

    AST_START_ONLY_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !s_q.active || last_edge) // R9
        else $error("start in the middle of a byte");

endmodule

// File: rtl/uspi_top.sv
module uspi_top
    import uspi_pkg::*;
#(
    parameter int unsigned DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [2:0]       bus_addr,
    input  logic [REG_W-1:0] bus_wdata,
    output logic [REG_W-1:0] bus_rdata,
    output logic             xclk,
    output logic             txd,
    output logic             txd_oe,
    input  logic             rxd
);

    typedef struct packed {
        logic             rx_en;
        logic             tx_req;
        logic             tx_drv;
        logic             buf_full;
        logic             rx_done;
        fmt_t             fmt;
        logic [DIV_W-1:0] baud;
        logic [REG_W-1:0] txbuf;
        logic [REG_W-1:0] rxbuf;
    } st_t;

    st_t              s_q, s_d;
    logic             spi_on;
    logic             start;
    logic             act_next;
    logic             tick;
    logic             sh_active;
    logic             sh_last;
    logic             sh_sck;
    logic             sh_mosi;
    logic [REG_W-1:0] sh_rx;
    logic [REG_W-1:0] baud_rd;

    always_comb begin
        s_d    = s_q;
        spi_on = (s_q.fmt.mode == M_SPI);

        if (bus_wr && bus_addr == A_CTRL) begin
            s_d.rx_en  = bus_wdata[0];
            s_d.tx_req = bus_wdata[1];
        end
        if (bus_wr && bus_addr == A_FMT)  s_d.fmt  = fmt_t'(bus_wdata[4:0]);
        if (bus_wr && bus_addr == A_BAUD) s_d.baud = bus_wdata[DIV_W-1:0];

        // transmit buffer hand-off to the shift engine
        start = s_q.tx_drv && spi_on && s_q.buf_full && (!sh_active || sh_last);
        if (start) s_d.buf_full = 1'b0;

        if (bus_wr && bus_addr == A_DATA && s_q.tx_req && spi_on
            && (!s_q.buf_full || start)) begin
            s_d.txbuf    = bus_wdata;
            s_d.buf_full = 1'b1;
        end

        // effective transmitter enable: held until everything queued has left
        act_next   = (sh_active && !sh_last) || start;
        s_d.tx_drv = spi_on && (s_q.tx_req || act_next || s_d.buf_full);

        // receive side
        if (sh_last && s_q.rx_en) begin
            s_d.rxbuf   = sh_rx;
            s_d.rx_done = 1'b1;
        end else if (bus_rd && bus_addr == A_DATA) begin
            s_d.rx_done = 1'b0;
        end
        if (bus_wr && bus_addr == A_CTRL && !bus_wdata[0]) begin
            s_d.rxbuf   = '0;
            s_d.rx_done = 1'b0;
        end
    end

    always_comb begin
        baud_rd              = '0;
        baud_rd[DIV_W-1:0]   = s_q.baud;
        unique case (bus_addr)
            A_DATA:  bus_rdata = s_q.rxbuf;
            A_STAT:  bus_rdata = {{(REG_W-2){1'b0}}, s_q.rx_done, !s_q.buf_full};
            A_CTRL:  bus_rdata = {{(REG_W-2){1'b0}}, s_q.tx_req, s_q.rx_en};
            A_FMT:   bus_rdata = {{(REG_W-5){1'b0}}, s_q.fmt};
            A_BAUD:  bus_rdata = baud_rd;
            default: bus_rdata = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    uspi_baud #(.DIV_W(DIV_W)) u_baud (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (sh_active),
        .limit (s_q.baud),
        .tick  (tick)
    );

    uspi_shift #(.DATA_W(REG_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .halt      (!spi_on),
        .start     (start),
        .din       (s_q.txbuf),
        .tick      (tick),
        .cpol      (s_q.fmt.cpol),
        .cpha      (s_q.fmt.cpha),
        .lsb_first (s_q.fmt.lsb_first),
        .miso      (rxd),
        .active    (sh_active),
        .last_edge (sh_last),
        .sck       (sh_sck),
        .mosi      (sh_mosi),
        .rx_word   (sh_rx)
    );

    assign xclk   = sh_sck;
    assign txd    = sh_mosi;
    assign txd_oe = s_q.tx_drv;

    AST_MODE_GATES_ENGINE: assert property (@(posedge clk) disable iff (!rst_n)
        !spi_on |=> !sh_active) // R1
        else $error("engine ran outside master SPI mode");

    AST_XFER_NEEDS_TX: assert property (@(posedge clk) disable iff (!rst_n)
        sh_active |-> s_q.tx_drv) // R12
        else $error("transfer without an enabled transmitter");

    AST_DRAIN_BEFORE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(s_q.tx_drv) && $stable(s_q.fmt) |-> !sh_active && !s_q.buf_full) // R10
        else $error("transmit line released with data pending");

    AST_RX_FLUSHED: assert property (@(posedge clk) disable iff (!rst_n)
        !s_q.rx_en |-> !s_q.rx_done && s_q.rxbuf == '0) // R11
        else $error("disabled receiver holds data");

endmodule

// File: tb/uspi_top_tb.sv
`timescale 1ns/1ps
module uspi_top_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [2:0] bus_addr = 3'd0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       xclk, txd, txd_oe, rxd;

    int nvec = 0;
    int nbad = 0;

    // monitor state
    logic       mon_on = 1'b0;
    logic       b_cpol = 1'b0, b_cpha = 1'b0, b_lsb = 1'b0;
    int         exp_iv = 1;
    int         n_edge = 0, n_badiv = 0, nbit = 0, ncap = 0;
    time        t_last = 0;
    logic [7:0] word = 8'h00;
    logic [7:0] cap [8];
    logic       lead;

    always #2 clk = ~clk;

    assign rxd = txd;   // loopback

    uspi_top u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .xclk(xclk), .txd(txd), .txd_oe(txd_oe), .rxd(rxd)
    );

    always @(xclk) begin
        if (mon_on) begin
            if (n_edge > 0 && ($time - t_last) != time'(exp_iv * 4)) n_badiv++;
            t_last = $time;
            n_edge++;
            lead = (xclk != b_cpol);
            if (lead != b_cpha) begin
                word = b_lsb ? {txd, word[7:1]} : {word[6:0], txd};
                nbit++;
                if (nbit == 8) begin
                    if (ncap < 8) cap[ncap] = word;
                    ncap++;
                    nbit = 0;
                end
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic mon_reset(input int iv);
        mon_on = 1'b0;
        n_edge = 0; n_badiv = 0; nbit = 0; ncap = 0; word = 8'h00;
        exp_iv = iv;
        mon_on = 1'b1;
    endtask

    task automatic wait_edges(input int n);
        for (int i = 0; i < 5000 && n_edge < n; i++) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    task automatic setup(input logic pol, input logic pha, input logic lsb,
                         input logic [7:0] baud, input logic [7:0] ctrl);
        mon_on = 1'b0;
        wr(3'd2, 8'h00);
        wr(3'd3, {3'b000, pol, pha, lsb, 2'b11});
        wr(3'd4, baud);
        wr(3'd2, ctrl);
        b_cpol = pol; b_cpha = pha; b_lsb = lsb;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [7:0] v;
        chk("R5 reset idle clock", {31'b0, xclk}, 32'd0);
        chk("R10 reset line released", {31'b0, txd_oe}, 32'd0);
        rd(3'd1, v); chk("R7 reset status", {24'b0, v}, 32'h01);
        rd(3'd2, v); chk("R12 reset ctrl", {24'b0, v}, 32'h00);
    endtask

    task automatic t_reserved;
        logic [7:0] v;
        wr(3'd2, 8'hFF); rd(3'd2, v); chk("R2 ctrl reserved", {24'b0, v}, 32'h03);
        wr(3'd3, 8'hFF); rd(3'd3, v); chk("R2 format reserved", {24'b0, v}, 32'h1F);
        wr(3'd2, 8'h00);
        repeat (3) @(negedge clk);
    endtask

    task automatic t_other_modes;
        logic [7:0] v;
        for (int m = 0; m < 3; m++) begin
            mon_on = 1'b0;
            wr(3'd2, 8'h00);
            wr(3'd3, {6'b0, 2'(m)});
            wr(3'd4, 8'd1);
            wr(3'd2, 8'h03);
            repeat (3) @(negedge clk);
            mon_reset(2);
            wr(3'd0, 8'h99);
            repeat (80) @(negedge clk);
            chk("R1 no clock outside SPI mode", n_edge, 0);
            chk("R1 line not driven", {31'b0, txd_oe}, 0);
            rd(3'd1, v); chk("R1 status untouched", {24'b0, v}, 32'h01);
        end
    endtask

    task automatic t_single(input logic pol, input logic pha, input logic lsb,
                            input logic [7:0] b, input logic [7:0] baud);
        logic [7:0] v;
        setup(pol, pha, lsb, baud, 8'h03);
        chk("R5 idle level", {31'b0, xclk}, {31'b0, pol});
        mon_reset(int'(baud) + 1);
        wr(3'd0, b);
        wait_edges(16);
        chk("R6 edges per byte", n_edge, 16);
        chk("R6 half period", n_badiv, 0);
        chk("R3 bit order on line", {24'b0, cap[0]}, {24'b0, b});
        rd(3'd1, v); chk("R8 receive complete", {30'b0, v[1:0]}, 32'h3);
        rd(3'd0, v); chk("R4 loopback data", {24'b0, v}, {24'b0, b});
        rd(3'd1, v); chk("R8 flag cleared by read", {31'b0, v[1]}, 0);
        chk("R5 idle after byte", {31'b0, xclk}, {31'b0, pol});
    endtask

    task automatic t_back_to_back;
        logic [7:0] v;
        setup(1'b0, 1'b1, 1'b0, 8'd2, 8'h03);
        mon_reset(3);
        wr(3'd0, 8'h5A);
        rd(3'd1, v); chk("R7 empty after move", {31'b0, v[0]}, 1);
        wr(3'd0, 8'hC3);
        rd(3'd1, v); chk("R7 full after write", {31'b0, v[0]}, 0);
        wait_edges(32);
        chk("R9 edge count", n_edge, 32);
        chk("R9 no gap", n_badiv, 0);
        chk("R9 first byte", {24'b0, cap[0]}, 32'h5A);
        chk("R9 second byte", {24'b0, cap[1]}, 32'hC3);
        rd(3'd0, v); chk("R8 latest byte", {24'b0, v}, 32'hC3);
    endtask

    task automatic t_full_ignored;
        setup(1'b1, 1'b0, 1'b1, 8'd9, 8'h03);
        mon_reset(10);
        wr(3'd0, 8'hA1);
        wr(3'd0, 8'hB2);
        wr(3'd0, 8'hC3);
        wait_edges(32);
        repeat (400) @(negedge clk);
        chk("R7 full write ignored edges", n_edge, 32);
        chk("R7 full write ignored bytes", ncap, 2);
        chk("R7 second byte kept", {24'b0, cap[1]}, 32'hB2);
    endtask

    task automatic t_drain;
        logic [7:0] v;
        setup(1'b0, 1'b0, 1'b0, 8'd1, 8'h03);
        mon_reset(2);
        wr(3'd0, 8'h6C);
        wr(3'd0, 8'h93);
        wr(3'd2, 8'h01);
        chk("R10 still driving", {31'b0, txd_oe}, 1);
        wait_edges(32);
        chk("R10 released", {31'b0, txd_oe}, 0);
        chk("R10 drained edges", n_edge, 32);
        chk("R10 second byte sent", {24'b0, cap[1]}, 32'h93);
        mon_reset(2);
        wr(3'd0, 8'h55);
        repeat (100) @(negedge clk);
        chk("R12 no transfer", n_edge, 0);
        rd(3'd1, v); chk("R12 write ignored", {31'b0, v[0]}, 1);
    endtask

    task automatic t_rx_flush;
        logic [7:0] v;
        setup(1'b1, 1'b1, 1'b1, 8'd0, 8'h03);
        mon_reset(1);
        wr(3'd0, 8'h2B);
        wait_edges(16);
        rd(3'd1, v); chk("R8 captured", {31'b0, v[1]}, 1);
        wr(3'd2, 8'h02);
        rd(3'd1, v); chk("R11 flag flushed", {31'b0, v[1]}, 0);
        rd(3'd0, v); chk("R11 buffer flushed", {24'b0, v}, 0);
        mon_reset(1);
        wr(3'd0, 8'h44);
        wait_edges(16);
        chk("R11 transmit still runs", n_edge, 16);
        rd(3'd1, v); chk("R11 no capture", {31'b0, v[1]}, 0);
        rd(3'd0, v); chk("R11 buffer empty", {24'b0, v}, 0);
    endtask

    initial begin
        logic [7:0] pat [8];
        pat[0] = 8'hB1; pat[1] = 8'h4E; pat[2] = 8'h17; pat[3] = 8'hC8;
        pat[4] = 8'h2D; pat[5] = 8'h96; pat[6] = 8'h63; pat[7] = 8'hF0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_reserved();
        t_other_modes();
        for (int i = 0; i < 8; i++)
            t_single(i[2], i[1], i[0], pat[i], 8'(i % 3));
        t_back_to_back();
        t_full_ignored();
        t_drain();
        t_rx_flush();
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        nbad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

endmodule